// File: doc/BRIEF.md
# In-Order Retirement Queue with Operand Forwarding

This block tracks instructions from issue to retirement in a pipeline that issues in order but lets its execution units finish out of order. An instruction gets a slot in a small circular queue when it is dispatched, and the slot number is its tag. Execution units later return the result (or a memory fault) for a tag, in any order. The queue retires completed slots one per cycle, strictly oldest first, and drives the register-file write port from the oldest slot.

Operands for the next instruction to be issued come from a lookup port. The port searches the slots still in flight for the youngest one that writes the requested register. A completed match supplies its value directly. A match that is still pending tells the issue stage to wait. No match means the register file copy is current.

A data-side memory fault arrives with the result and is only recorded in the slot. It takes effect only when that slot becomes the oldest. At that point the block raises a one-cycle discard pulse instead of a register write. Every slot, including the faulting one, is dropped, and the allocation pointer returns to the retirement pointer.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty: `disp_ready_o`=1, `disp_tag_o`=0, `cm_valid_o`=0, `abort_o`=0, `lk_hit_o`=0.
- R2: Each accepted dispatch (`disp_valid_i` and `disp_ready_o` high at a clock edge) takes the tag shown on `disp_tag_o`. Successive tags increase by one modulo 8.
- R3: With 8 slots in flight, `disp_ready_o` is 0 and a dispatch attempt allocates nothing: its destination register is absent from later lookups.
- R4: A result write stores its value in the slot named by `wr_tag_i` whatever the order of arrival. A write to an unallocated tag, or to a slot already completed, is ignored.
- R5: `cm_valid_o` is high only while the oldest slot is complete and not faulted. It then presents that slot's register and value and retires it at the edge. Retirement is in dispatch order, one slot per cycle.
- R6: On a lookup, when the youngest in-flight slot with the requested destination register is complete, `lk_hit_o`=1, `lk_ready_o`=1 and `lk_data_o` is that slot's value. An older slot for the same register is not used.
- R7: If that youngest matching slot is still pending or faulted, `lk_hit_o`=1 and `lk_ready_o`=0. If no slot matches, `lk_hit_o`=0.
- R8: A write with `wr_abort_i`=1 has no visible effect until its slot is the oldest. Then `abort_o` is 1 for one cycle with `cm_valid_o`=0. All slots are then discarded, and the next dispatch receives the faulting slot's tag.
- R9: In the cycle `abort_o` is high, `disp_ready_o` is 0 and both dispatch and result writes are ignored.
- R10: When the queue holds 8 slots and the oldest retires, the next cycle accepts a dispatch while the following retirement is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dest_i | input | 4 | Destination register of dispatched instruction |
| disp_ready_o | output | 1 | Dispatch can be accepted this cycle |
| disp_tag_o | output | 3 | Tag the next dispatch receives |
| wr_valid_i | input | 1 | Result write strobe |
| wr_tag_i | input | 3 | Tag the result belongs to |
| wr_data_i | input | 32 | Result value |
| wr_abort_i | input | 1 | Result carries a memory fault |
| lk_reg_i | input | 4 | Register to look up |
| lk_hit_o | output | 1 | An in-flight slot writes that register |
| lk_ready_o | output | 1 | The youngest such slot has a usable value |
| lk_data_o | output | 32 | Forwarded value |
| cm_valid_o | output | 1 | Register-file write this cycle |
| cm_reg_o | output | 4 | Register written |
| cm_data_o | output | 32 | Value written |
| abort_o | output | 1 | Oldest slot faulted; all slots discarded |

## Verification
The checker watches every cycle for these properties: the occupancy never exceeds the depth, dispatch is refused when full or during a discard, retirement and discard never coincide, each retirement advances the oldest pointer by exactly one, a discard leaves the queue empty, and a ready lookup always implies a hit. It cannot see the values that are retired or forwarded. The bench scenarios show those instead, by keeping a scoreboard of program-order retirements. The scenarios also cover out-of-order completion, choosing the youngest of several matching slots, ignoring stray and repeated writes, the wrap of tags, dispatch in the cycle after a retirement from full, and the tag reuse after a discard.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned ROB_DEPTH  = 8;
  localparam int unsigned ARCH_REG_W = 4;
  localparam int unsigned WORD_W     = 32;

  // What the oldest slot does this cycle
  typedef enum logic [1:0] {
    HEAD_IDLE   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_ABORT  = 2'd2
  } head_act_e;
endpackage

// File: rtl/rob_qctrl.sv
// Head/tail/occupancy bookkeeping of the circular queue.
module rob_qctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);
  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    if (flush_i) begin
      tail_d  = head_q;
      count_d = '0;
    end else begin
      if (push_i) tail_d = tail_q + 1'b1;
      if (pop_i)  head_d = head_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_d = count_q + 1'b1;
        2'b01:   count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;
endmodule

// File: rtl/rob_slot.sv
// One queue slot: occupancy, completion, fault flag, destination and value.
module rob_slot #(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [REG_W-1:0]  dest_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_abt_i,
  input  logic              retire_i,
  input  logic              clear_i,
  output logic              vld_o,
  output logic              done_o,
  output logic              abt_o,
  output logic [REG_W-1:0]  dest_o,
  output logic [DATA_W-1:0] val_o
);
  logic              vld_q, vld_d, done_q, done_d, abt_q, abt_d;
  logic [REG_W-1:0]  dest_q, dest_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic              wr_en;

  // a result lands only in an occupied slot that is still pending
  assign wr_en = wr_i && vld_q && !done_q;

  always_comb begin
    vld_d  = vld_q;
    done_d = done_q;
    abt_d  = abt_q;
    dest_d = dest_q;
    val_d  = val_q;
    if (clear_i) begin
      vld_d  = 1'b0;
      done_d = 1'b0;
      abt_d  = 1'b0;
    end else if (alloc_i) begin
      vld_d  = 1'b1;
      done_d = 1'b0;
      abt_d  = 1'b0;
      dest_d = dest_i;
    end else if (retire_i) begin
      vld_d  = 1'b0;
      done_d = 1'b0;
    end else if (wr_en) begin
      done_d = 1'b1;
      abt_d  = wr_abt_i;
      val_d  = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      abt_q  <= 1'b0;
      dest_q <= '0;
      val_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
      abt_q  <= abt_d;
      dest_q <= dest_d;
      val_q  <= val_d;
    end
  end

  assign vld_o  = vld_q;
  assign done_o = done_q;
  assign abt_o  = abt_q;
  assign dest_o = dest_q;
  assign val_o  = val_q;
endmodule

// File: rtl/rob_fwd.sv
// Age-ordered search for the youngest in-flight slot writing a register.
module rob_fwd #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0]             done_i,
  input  logic [DEPTH-1:0]             abt_i,
  input  logic [DEPTH-1:0][REG_W-1:0]  dest_i,
  input  logic [DEPTH-1:0][DATA_W-1:0] val_i,
  input  logic [TAG_W-1:0]             head_i,
  input  logic [REG_W-1:0]             reg_i,
  output logic                         hit_o,
  output logic                         ready_o,
  output logic [DATA_W-1:0]            data_o
);
  always_comb begin
    logic [TAG_W-1:0] idx;
    hit_o   = 1'b0;
    ready_o = 1'b0;
    data_o  = '0;
    // walk from oldest to youngest; a later match overrides an earlier one
    for (int i = 0; i < DEPTH; i++) begin
      idx = head_i + TAG_W'(i);
      if (vld_i[idx] && dest_i[idx] == reg_i) begin
        hit_o   = 1'b1;
        ready_o = done_i[idx] && !abt_i[idx];
        data_o  = val_i[idx];
      end
    end
  end
endmodule

// File: rtl/rob_core.sv
// Reorder queue top: dispatch, tagged result writes, forwarding lookup,
// in-order commit and deferred fault discard. DEPTH must be a power of two.
module rob_core
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = ROB_DEPTH,
  parameter int unsigned REG_W  = ARCH_REG_W,
  parameter int unsigned DATA_W = WORD_W,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid_i,
  input  logic [REG_W-1:0]  disp_dest_i,
  output logic              disp_ready_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  input  logic              wr_valid_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_abort_i,
  input  logic [REG_W-1:0]  lk_reg_i,
  output logic              lk_hit_o,
  output logic              lk_ready_o,
  output logic [DATA_W-1:0] lk_data_o,
  output logic              cm_valid_o,
  output logic [REG_W-1:0]  cm_reg_o,
  output logic [DATA_W-1:0] cm_data_o,
  output logic              abort_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             push, pop, flush;
  head_act_e        head_act;

  logic [DEPTH-1:0]             s_vld, s_done, s_abt;
  logic [DEPTH-1:0][REG_W-1:0]  s_dest;
  logic [DEPTH-1:0][DATA_W-1:0] s_val;

  rob_qctrl #(.DEPTH(DEPTH)) u_qctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .pop_i   (pop),
    .flush_i (flush),
    .head_o  (head_q),
    .tail_o  (tail_q),
    .count_o (count_q)
  );

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      rob_slot #(.REG_W(REG_W), .DATA_W(DATA_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_i   (push && tail_q == TAG_W'(g)),
        .dest_i    (disp_dest_i),
        .wr_i      (wr_valid_i && !flush && wr_tag_i == TAG_W'(g)),
        .wr_data_i (wr_data_i),
        .wr_abt_i  (wr_abort_i),
        .retire_i  (pop && head_q == TAG_W'(g)),
        .clear_i   (flush),
        .vld_o     (s_vld[g]),
        .done_o    (s_done[g]),
        .abt_o     (s_abt[g]),
        .dest_o    (s_dest[g]),
        .val_o     (s_val[g])
      );
    end
  endgenerate

  // decision for the oldest slot
  always_comb begin
    head_act = HEAD_IDLE;
    if (s_vld[head_q] && s_done[head_q])
      head_act = s_abt[head_q] ? HEAD_ABORT : HEAD_RETIRE;
  end

  assign pop   = (head_act == HEAD_RETIRE);
  assign flush = (head_act == HEAD_ABORT);

  assign disp_ready_o = (count_q != CNT_W'(DEPTH)) && !flush;
  assign disp_tag_o   = tail_q;
  assign push         = disp_valid_i && disp_ready_o;

  assign cm_valid_o = pop;
  assign cm_reg_o   = s_dest[head_q];
  assign cm_data_o  = s_val[head_q];
  assign abort_o    = flush;

  rob_fwd #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_fwd (
    .vld_i   (s_vld),
    .done_i  (s_done),
    .abt_i   (s_abt),
    .dest_i  (s_dest),
    .val_i   (s_val),
    .head_i  (head_q),
    .reg_i   (lk_reg_i),
    .hit_o   (lk_hit_o),
    .ready_o (lk_ready_o),
    .data_o  (lk_data_o)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = TAG_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_ready_o,
  input logic             cm_valid_o,
  input logic             abort_o,
  input logic             lk_hit_o,
  input logic             lk_ready_o,
  input logic [TAG_W-1:0] head_q,
  input logic [CNT_W-1:0] count_q
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNT_W'(DEPTH)) |-> !disp_ready_o);

  p_commit_abort_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_valid_o && abort_o));

  p_head_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid_o |=> (head_q == TAG_W'($past(head_q) + 1'b1)));

  p_abort_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (count_q == '0) && !lk_hit_o && !cm_valid_o);

  p_abort_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !disp_ready_o);

  p_ready_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready_o |-> lk_hit_o);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .disp_ready_o (disp_ready_o),
  .cm_valid_o   (cm_valid_o),
  .abort_o      (abort_o),
  .lk_hit_o     (lk_hit_o),
  .lk_ready_o   (lk_ready_o),
  .head_q       (head_q),
  .count_q      (count_q)
);

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid_i = 1'b0;
  logic [3:0]  disp_dest_i = '0;
  logic        disp_ready_o;
  logic [2:0]  disp_tag_o;
  logic        wr_valid_i = 1'b0;
  logic [2:0]  wr_tag_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        wr_abort_i = 1'b0;
  logic [3:0]  lk_reg_i = '0;
  logic        lk_hit_o, lk_ready_o;
  logic [31:0] lk_data_o;
  logic        cm_valid_o;
  logic [3:0]  cm_reg_o;
  logic [31:0] cm_data_o;
  logic        abort_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [35:0] exp_q[$];

  always #10 clk = ~clk; // 50 MHz

  rob_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid_i(disp_valid_i), .disp_dest_i(disp_dest_i),
    .disp_ready_o(disp_ready_o), .disp_tag_o(disp_tag_o),
    .wr_valid_i(wr_valid_i), .wr_tag_i(wr_tag_i), .wr_data_i(wr_data_i),
    .wr_abort_i(wr_abort_i), .lk_reg_i(lk_reg_i), .lk_hit_o(lk_hit_o),
    .lk_ready_o(lk_ready_o), .lk_data_o(lk_data_o), .cm_valid_o(cm_valid_o),
    .cm_reg_o(cm_reg_o), .cm_data_o(cm_data_o), .abort_o(abort_o)
  );

  task automatic chk(string req, string what, logic [35:0] act, logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: every retirement must match the next program-order expectation (R5)
  always @(negedge clk) begin
    if (rst_n && cm_valid_o) begin
      if (exp_q.size() == 0) begin
        chk("R5", "unexpected retirement", {cm_reg_o, cm_data_o}, 36'h0);
      end else begin
        chk("R5", "retired reg/value", {cm_reg_o, cm_data_o}, exp_q.pop_front());
      end
    end
  end

  // driver: dispatch and record the retirement it should produce
  task automatic dispatch(input logic [3:0] dest, input logic [31:0] val,
                          input bit commits, input logic [2:0] exp_tag);
    @(negedge clk);
    chk("R2", "dispatch ready", 36'(disp_ready_o), 36'h1);
    chk("R2", "dispatch tag", 36'(disp_tag_o), 36'(exp_tag));
    disp_valid_i = 1'b1;
    disp_dest_i  = dest;
    if (commits) exp_q.push_back({dest, val});
    @(posedge clk); #1;
    disp_valid_i = 1'b0;
  endtask

  task automatic write_res(input logic [2:0] tag, input logic [31:0] val, input bit abt);
    @(negedge clk);
    wr_valid_i = 1'b1;
    wr_tag_i   = tag;
    wr_data_i  = val;
    wr_abort_i = abt;
    @(posedge clk); #1;
    wr_valid_i = 1'b0;
    wr_abort_i = 1'b0;
  endtask

  task automatic look(string req, input logic [3:0] r, input bit hit,
                      input bit rdy, input logic [31:0] data);
    @(negedge clk);
    lk_reg_i = r;
    #1;
    chk(req, "lookup hit", 36'(lk_hit_o), 36'(hit));
    chk(req, "lookup ready", 36'(lk_ready_o), 36'(rdy));
    if (rdy) chk(req, "lookup data", 36'(lk_data_o), 36'(data));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "ready", 36'(disp_ready_o), 36'h1);
    chk("R1", "tag", 36'(disp_tag_o), 36'h0);
    chk("R1", "commit", 36'(cm_valid_o), 36'h0);
    chk("R1", "abort", 36'(abort_o), 36'h0);
    chk("R1", "hit", 36'(lk_hit_o), 36'h0);

    // --- out-of-order completion, forwarding (R2 R4 R5 R6 R7)
    dispatch(4'd1, 32'h11, 1, 3'd0);
    dispatch(4'd2, 32'h22, 1, 3'd1);
    dispatch(4'd1, 32'h33, 1, 3'd2);
    look("R7", 4'd1, 1, 0, 0);          // youngest reg1 slot pending
    look("R7", 4'd5, 0, 0, 0);          // no slot for reg5
    write_res(3'd5, 32'hDEAD, 0);       // R4 stray tag
    write_res(3'd2, 32'h33, 0);
    look("R6", 4'd1, 1, 1, 32'h33);     // youngest of two reg1 slots
    chk("R5", "no retire while oldest pending", 36'(cm_valid_o), 36'h0);
    write_res(3'd1, 32'h22, 0);
    write_res(3'd1, 32'h99, 0);         // R4 repeat write ignored
    look("R4", 4'd2, 1, 1, 32'h22);
    chk("R5", "still no retire", 36'(cm_valid_o), 36'h0);
    write_res(3'd0, 32'h11, 0);
    repeat (4) @(posedge clk);
    look("R5", 4'd1, 0, 0, 0);

    // --- fill to capacity with tag wrap (R2 R3 R4 R10)
    for (int d = 0; d < 8; d++)
      dispatch(4'(d), 32'h100 + 32'(d), 1, 3'(3 + d));
    @(negedge clk);
    chk("R3", "full not ready", 36'(disp_ready_o), 36'h0);
    disp_valid_i = 1'b1;
    disp_dest_i  = 4'd8;
    @(posedge clk); #1;
    disp_valid_i = 1'b0;
    look("R3", 4'd8, 0, 0, 0);
    look("R4", 4'd2, 1, 0, 0);          // tag5 untouched by stray write
    for (int d = 7; d >= 0; d--)
      write_res(3'(3 + d), 32'h100 + 32'(d), 0);
    @(negedge clk);
    chk("R10", "retiring while full", 36'(cm_valid_o), 36'h1);
    chk("R10", "full blocks dispatch", 36'(disp_ready_o), 36'h0);
    @(negedge clk);
    chk("R10", "retire continues", 36'(cm_valid_o), 36'h1);
    chk("R10", "ready after retire", 36'(disp_ready_o), 36'h1);
    chk("R10", "wrapped tag", 36'(disp_tag_o), 36'h3);
    disp_valid_i = 1'b1;
    disp_dest_i  = 4'd9;
    exp_q.push_back({4'd9, 32'h909});
    @(posedge clk); #1;
    disp_valid_i = 1'b0;
    repeat (8) @(posedge clk);
    write_res(3'd3, 32'h909, 0);
    repeat (3) @(posedge clk);

    // --- deferred fault (R8 R9)
    dispatch(4'd3, 32'h44, 1, 3'd4);
    dispatch(4'd4, 32'h0, 0, 3'd5);
    dispatch(4'd5, 32'h0, 0, 3'd6);
    write_res(3'd6, 32'h66, 0);
    write_res(3'd5, 32'hBAD, 1);
    look("R7", 4'd4, 1, 0, 0);          // faulted slot not usable
    chk("R8", "fault deferred", 36'(abort_o), 36'h0);
    write_res(3'd4, 32'h44, 0);
    @(negedge clk);
    chk("R8", "oldest retires first", 36'(cm_valid_o), 36'h1);
    chk("R8", "no discard yet", 36'(abort_o), 36'h0);
    @(negedge clk);
    chk("R8", "discard pulse", 36'(abort_o), 36'h1);
    chk("R8", "no write on discard", 36'(cm_valid_o), 36'h0);
    chk("R9", "dispatch blocked", 36'(disp_ready_o), 36'h0);
    disp_valid_i = 1'b1;
    disp_dest_i  = 4'd7;
    @(posedge clk); #1;
    disp_valid_i = 1'b0;
    @(negedge clk);
    chk("R8", "single-cycle pulse", 36'(abort_o), 36'h0);
    chk("R8", "tag reused", 36'(disp_tag_o), 36'h5);
    look("R8", 4'd5, 0, 0, 0);
    look("R9", 4'd7, 0, 0, 0);
    dispatch(4'd6, 32'h77, 1, 3'd5);
    write_res(3'd5, 32'h77, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5", "all expected retirements seen", 36'(exp_q.size()), 36'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule